// File: doc/BRIEF.md
# One-Wire ROM Search Accelerator

This block is the search datapath of a single-wire bus master. While search mode is on, one host byte starts one exchange. The exchange resolves a group of ROM bits, four by default. For each of these bits the block runs three bus time slots:

1. It reads the bit as the devices drive it.
2. It reads the complement of that bit.
3. It writes the direction it has chosen. Devices whose ROM bit differs from the written value leave the search.

At the end of the exchange the block returns one byte. In that byte the resolved ROM bits are interleaved with conflict flags.

The host first issues a bus reset and sends the search command byte through the normal byte path. It then raises the search enable and makes sixteen exchanges, one per nibble of the 64-bit ROM ID. The direction bits it places in each transmit byte are the choices it wants at conflicting positions. The host keeps track of the last conflict from one pass to the next; the block does not. Clearing the enable leaves search mode and abandons any exchange in progress.

The bus pin is open-drain. The block asserts a pull-low request and senses the line through a synchronizer. Every time value is a parameter counted in clock cycles.

Top module: `onewire_search_accel`

## Requirements
- R1: After reset the bus is released, `rx_full` is 0 and `busy` is 0.
- R2: When `srch_en` is 1 and the block is idle, a `tx_wr` pulse starts an exchange of exactly 3*NB time slots. The slots for each ROM bit come in the order read-true, read-complement, write. ROM bit 0 of the group is handled first.
- R3: Each slot lasts T_SLOT cycles, and the slots of one exchange follow each other with no gap. Read slots and write-1 slots pull the line low for T_LOW cycles. Write-0 slots pull it low for T_W0LOW cycles.
- R4: If both reads of a bit return 0, the conflict flag is 1. The written and reported bit is then the direction bit at position 2k+1 of the transmit byte, where k is the bit's place in the group. A transmit byte of 0x00 therefore takes the 0 branch at every conflict.
- R5: If the two reads differ, the written and reported bit equals the first read and the flag is 0.
- R6: If both reads return 1 (no device answering), the reported bit is 1, the flag is 1, and a 1 is written.
- R7: In the response byte, ROM bit k of the group is at position 2k+1 and its flag is at position 2k.
- R8: `rx_data` is loaded and `rx_full` set in the cycle after the last slot of the exchange ends, and not earlier. A `rx_rd` pulse clears `rx_full`.
- R9: A `tx_wr` pulse while `srch_en` is 0, or while an exchange is running, has no effect on the bus, on `rx_full` or on the response.
- R10: Clearing `srch_en` during an exchange releases the bus and drops `busy` in the next cycle, and no response is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srch_en | input | 1 | Search mode enable |
| tx_wr | input | 1 | Transmit byte strobe; starts an exchange |
| tx_data | input | 2*NB | Direction bits at odd positions |
| rx_rd | input | 1 | Response read strobe; clears `rx_full` |
| rx_data | output | 2*NB | Packed response: ROM bits odd, flags even |
| rx_full | output | 1 | Response waiting to be read |
| busy | output | 1 | Exchange in progress |
| bus_in | input | 1 | Sensed bus line level |
| bus_drive_low | output | 1 | Request to pull the bus line low |

## Verification
The bench builds the block with NB=4, T_SLOT=20, T_LOW=2, T_SAMPLE=8, T_W0LOW=14 and SYNC_STAGES=2. With these values a complete 64-bit search of sixteen exchanges takes only a few thousand cycles, so several full searches fit in one run.

A bus model of up to three devices drives the read slots and drops devices according to the level it senses in each write slot. This exercises:
- conflicts at every ROM position;
- a search with no device present;
- devices that differ only in bit 0;
- random IDs with random direction bytes.

The short slots also allow the low-pulse widths, the slot spacing and the moment of response delivery to be checked on every slot.

// File: rtl/owsra_pkg.sv
package owsra_pkg;

  // Kind of bus time slot; the order is the order of a triplet.
  typedef enum logic [1:0] {
    SLOT_RD_TRUE = 2'd0,
    SLOT_RD_CMP  = 2'd1,
    SLOT_WR      = 2'd2
  } slot_kind_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/owsra_slot_timer.sv
module owsra_slot_timer
  import owsra_pkg::*;
#(
  parameter int T_SLOT   = 17500,
  parameter int T_LOW    = 500,
  parameter int T_W0LOW  = 15000,
  parameter int T_SAMPLE = 3000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  slot_kind_e kind,
  input  logic       wbit,
  input  logic       abort,
  input  logic       line_s,
  output logic       drive_low,
  output logic       smp_bit,
  output logic       done
);

  localparam int CW = $clog2(T_SLOT + 1);

  logic          active_q, active_d;
  logic [CW-1:0] cnt_q, cnt_d;
  slot_kind_e    kind_q, kind_d;
  logic          wbit_q, wbit_d;
  logic          smp_q, smp_d;
  logic [CW-1:0] low_len;

  assign done      = active_q && (cnt_q == CW'(T_SLOT - 1));
  assign low_len   = (kind_q == SLOT_WR && !wbit_q) ? CW'(T_W0LOW) : CW'(T_LOW);
  assign drive_low = active_q && (cnt_q < low_len);
  assign smp_bit   = smp_q;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    kind_d   = kind_q;
    wbit_d   = wbit_q;
    smp_d    = smp_q;
    if (abort) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else begin
      if (active_q && cnt_q == CW'(T_SAMPLE)) smp_d = line_s;
      if (!active_q || done) begin
        // a new slot may start right where the previous one ends
        if (go) begin
          active_d = 1'b1;
          cnt_d    = '0;
          kind_d   = kind;
          wbit_d   = wbit;
        end else begin
          active_d = 1'b0;
        end
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      kind_q   <= SLOT_RD_TRUE;
      wbit_q   <= 1'b1;
      smp_q    <= 1'b1;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      kind_q   <= kind_d;
      wbit_q   <= wbit_d;
      smp_q    <= smp_d;
    end
  end

  // The sequencer only starts a slot when the timer is free or finishing.
  assert_go_when_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (!active_q || done));

  // The pull-low request always ends before the slot does.
  assert_release_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !drive_low);

  // A falling edge on the line always belongs to a freshly started slot.
  assert_low_starts_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_low) |-> $past(go));

endmodule

// File: rtl/owsra_bit_resolve.sv
module owsra_bit_resolve (
  input  logic rd_true,
  input  logic rd_cmp,
  input  logic dir,
  output logic rom_bit,
  output logic conflict
);

  logic both_low, both_high;

  assign both_low  = !rd_true && !rd_cmp;
  assign both_high = rd_true && rd_cmp;
  assign conflict  = both_low || both_high;
  // both high leaves rd_true at 1, which is the reported value for that case
  assign rom_bit   = both_low ? dir : rd_true;

endmodule

// File: rtl/owsra_triplet_seq.sv
module owsra_triplet_seq
  import owsra_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tx_wr,
  input  logic [2*NB-1:0] tx_data,
  input  logic          slot_done,
  input  logic          smp_bit,
  output logic          slot_go,
  output slot_kind_e    slot_kind,
  output logic          slot_wbit,
  output logic          slot_abort,
  output logic          busy,
  output logic          xchg_done,
  output logic [NB-1:0] rom_bits,
  output logic [NB-1:0] dsc_bits
);

  localparam int RW = 2 * NB;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  seq_state_e    st_q, st_d;
  slot_kind_e    ph_q, ph_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [RW-1:0] tx_q, tx_d;
  logic          true_q, true_d;
  logic [NB-1:0] rom_q, rom_d;
  logic [NB-1:0] dsc_q, dsc_d;
  logic          dir_bit, res_rom, res_dsc, last_bit;

  assign dir_bit  = tx_q[{idx_q, 1'b1}];
  assign last_bit = (idx_q == IW'(NB - 1));

  owsra_bit_resolve u_resolve (
    .rd_true  (true_q),
    .rd_cmp   (smp_bit),
    .dir      (dir_bit),
    .rom_bit  (res_rom),
    .conflict (res_dsc)
  );

  always_comb begin
    st_d       = st_q;
    ph_d       = ph_q;
    idx_d      = idx_q;
    tx_d       = tx_q;
    true_d     = true_q;
    rom_d      = rom_q;
    dsc_d      = dsc_q;
    slot_go    = 1'b0;
    slot_kind  = SLOT_RD_TRUE;
    slot_wbit  = 1'b1;
    slot_abort = 1'b0;
    xchg_done  = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        if (en && tx_wr) begin
          st_d    = SEQ_RUN;
          tx_d    = tx_data;
          idx_d   = '0;
          ph_d    = SLOT_RD_TRUE;
          rom_d   = '0;
          dsc_d   = '0;
          slot_go = 1'b1;
        end
      end
      default: begin
        if (!en) begin
          st_d       = SEQ_IDLE;
          slot_abort = 1'b1;
        end else if (slot_done) begin
          case (ph_q)
            SLOT_RD_TRUE: begin
              true_d    = smp_bit;
              ph_d      = SLOT_RD_CMP;
              slot_go   = 1'b1;
              slot_kind = SLOT_RD_CMP;
            end
            SLOT_RD_CMP: begin
              rom_d[idx_q] = res_rom;
              dsc_d[idx_q] = res_dsc;
              ph_d         = SLOT_WR;
              slot_go      = 1'b1;
              slot_kind    = SLOT_WR;
              slot_wbit    = res_rom;
            end
            default: begin
              if (last_bit) begin
                st_d      = SEQ_IDLE;
                xchg_done = 1'b1;
              end else begin
                idx_d   = idx_q + IW'(1);
                ph_d    = SLOT_RD_TRUE;
                slot_go = 1'b1;
              end
            end
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      ph_q   <= SLOT_RD_TRUE;
      idx_q  <= '0;
      tx_q   <= '0;
      true_q <= 1'b1;
      rom_q  <= '0;
      dsc_q  <= '0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      idx_q  <= idx_d;
      tx_q   <= tx_d;
      true_q <= true_d;
      rom_q  <= rom_d;
      dsc_q  <= dsc_d;
    end
  end

  assign busy     = (st_q == SEQ_RUN);
  assign rom_bits = rom_q;
  assign dsc_bits = dsc_q;

  // Conflict with both reads low: the host direction bit is written.
  assert_dir_on_conflict_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_go && slot_kind == SLOT_WR && !true_q && !smp_bit) |-> (slot_wbit == tx_q[{idx_q, 1'b1}]));

  // Reads that differ: the first read is written.
  assert_follow_true_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_go && slot_kind == SLOT_WR && (true_q != smp_bit)) |-> (slot_wbit == true_q));

  // No answer on either read: a 1 is written.
  assert_silent_writes_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_go && slot_kind == SLOT_WR && true_q && smp_bit) |-> slot_wbit);

  // The exchange ends only on the completion of a slot.
  assert_done_on_slot_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xchg_done |-> slot_done);

  // Dropping the enable ends the exchange at once.
  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !en) |=> !busy);

endmodule

// File: rtl/owsra_resp_pack.sv
module owsra_resp_pack #(
  parameter int NB = 4
) (
  input  logic [NB-1:0]   rom_bits,
  input  logic [NB-1:0]   dsc_bits,
  output logic [2*NB-1:0] resp
);

  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign resp[2*k+1] = rom_bits[k];
    assign resp[2*k]   = dsc_bits[k];
  end

endmodule

// File: rtl/onewire_search_accel.sv
module onewire_search_accel
  import owsra_pkg::*;
#(
  parameter int NB          = 4,
  parameter int T_SLOT      = 17500,
  parameter int T_LOW       = 500,
  parameter int T_W0LOW     = 15000,
  parameter int T_SAMPLE    = 3000,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            srch_en,
  input  logic            tx_wr,
  input  logic [2*NB-1:0] tx_data,
  input  logic            rx_rd,
  output logic [2*NB-1:0] rx_data,
  output logic            rx_full,
  output logic            busy,
  input  logic            bus_in,
  output logic            bus_drive_low
);

  localparam int RW = 2 * NB;

  logic [1:0] rst_pipe_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i = rst_pipe_q[1];

  // Line synchronizer; the idle line is high.
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line_s;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_i) begin
      if (!rst_i) sync_q[s] <= 1'b1;
      else if (s == 0) sync_q[s] <= bus_in;
      else sync_q[s] <= sync_q[(s > 0) ? s - 1 : 0];
    end
  end
  assign line_s = sync_q[SYNC_STAGES-1];

  logic          slot_go, slot_wbit, slot_abort, slot_done, smp_bit;
  slot_kind_e    slot_kind;
  logic          xchg_done;
  logic [NB-1:0] rom_bits, dsc_bits;
  logic [RW-1:0] resp;

  owsra_triplet_seq #(.NB(NB)) u_seq (
    .clk        (clk),
    .rst_n      (rst_i),
    .en         (srch_en),
    .tx_wr      (tx_wr),
    .tx_data    (tx_data),
    .slot_done  (slot_done),
    .smp_bit    (smp_bit),
    .slot_go    (slot_go),
    .slot_kind  (slot_kind),
    .slot_wbit  (slot_wbit),
    .slot_abort (slot_abort),
    .busy       (busy),
    .xchg_done  (xchg_done),
    .rom_bits   (rom_bits),
    .dsc_bits   (dsc_bits)
  );

  owsra_slot_timer #(
    .T_SLOT   (T_SLOT),
    .T_LOW    (T_LOW),
    .T_W0LOW  (T_W0LOW),
    .T_SAMPLE (T_SAMPLE)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_i),
    .go        (slot_go),
    .kind      (slot_kind),
    .wbit      (slot_wbit),
    .abort     (slot_abort),
    .line_s    (line_s),
    .drive_low (bus_drive_low),
    .smp_bit   (smp_bit),
    .done      (slot_done)
  );

  owsra_resp_pack #(.NB(NB)) u_pack (
    .rom_bits (rom_bits),
    .dsc_bits (dsc_bits),
    .resp     (resp)
  );

  logic          rx_full_q, rx_full_d;
  logic [RW-1:0] rx_data_q, rx_data_d;

  // The final slot's write is complete before the bits are copied out.
  // rom_bits is stable from the last read-complement slot onward.
  always_comb begin
    rx_full_d = rx_full_q;
    rx_data_d = rx_data_q;
    if (rx_rd) rx_full_d = 1'b0;
    if (xchg_done) begin
      rx_full_d = 1'b1;
      rx_data_d = resp;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      rx_full_q <= 1'b0;
      rx_data_q <= '0;
    end else begin
      rx_full_q <= rx_full_d;
      rx_data_q <= rx_data_d;
    end
  end

  assign rx_full = rx_full_q;
  assign rx_data = rx_data_q;

  assert_rx_after_exchange_R8: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(rx_full) |-> $past(xchg_done));

  assert_idle_bus_released_R1: assert property (@(posedge clk) disable iff (!rst_i)
    !busy |-> !bus_drive_low);

  assert_ignore_when_off_R9: assert property (@(posedge clk) disable iff (!rst_i)
    (tx_wr && !srch_en && !busy) |=> !busy);

endmodule

// File: tb/tb_onewire_search_accel.sv
module tb_onewire_search_accel;

  localparam int NB       = 4;
  localparam int T_SLOT   = 20;
  localparam int T_LOW    = 2;
  localparam int T_W0LOW  = 14;
  localparam int T_SAMPLE = 8;
  localparam int WDOG     = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       srch_en = 1'b0;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       rx_rd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_full, busy, drv;
  logic       dev_pull = 1'b0;
  wire        line = !(drv || dev_pull);

  always #2 clk = !clk;

  onewire_search_accel #(
    .NB(NB), .T_SLOT(T_SLOT), .T_LOW(T_LOW), .T_W0LOW(T_W0LOW),
    .T_SAMPLE(T_SAMPLE), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .srch_en(srch_en), .tx_wr(tx_wr),
    .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full),
    .busy(busy), .bus_in(line), .bus_drive_low(drv)
  );

  // shared search setup, written by the stimulus only
  logic [63:0] ids [3];
  logic [2:0]  dev_init = 3'b000;
  int          srch_gen = 0;
  int          srch_base = 0;
  logic [7:0]  dir_cur = 8'h00;

  int n_chk = 0, n_fail = 0;
  int m_chk = 0, m_fail = 0;

  // ---------------- bus monitor and device model ----------------
  int         cyc = 0;
  int         tot_slots = 0;
  int         slot_cyc = 0;
  int         low_cnt = 0;
  int         seen_gen = 0;
  logic       prev_drv = 1'b0;
  logic       prev_busy = 1'b0;
  logic [2:0] dev_act = 3'b000;
  logic       t_m = 1'b1, c_m = 1'b1, w_exp = 1'b1;
  int         ph_m = 0, pos_m = 0;

  function automatic void resolve(input logic t, input logic c, input logic d,
                                  output logic r, output logic f);
    if (!t && !c) begin r = d; f = 1'b1; end
    else if (t && c) begin r = 1'b1; f = 1'b1; end
    else begin r = t; f = 1'b0; end
  endfunction

  task automatic mchk(input bit ok, input string msg, input longint act, input longint exp);
    m_chk++;
    if (!ok) begin
      m_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", msg, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      m_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG);
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_chk + m_chk + 1, n_fail + m_fail);
      $finish;
    end
    if (rst_n) begin
      logic rr, ff;
      int   exp_low;
      if (srch_gen != seen_gen) begin
        seen_gen = srch_gen;
        dev_act  = dev_init;
      end
      if (drv && !prev_drv) begin
        // R3: back-to-back slots within one exchange are T_SLOT apart
        if (prev_busy) mchk(slot_cyc + 1 == T_SLOT, "R3 slot period", slot_cyc + 1, T_SLOT);
        tot_slots++;
        slot_cyc = 0;
        low_cnt  = 1;
        ph_m  = (tot_slots - srch_base - 1) % 3;
        pos_m = (tot_slots - srch_base - 1) / 3;
        if (ph_m == 0) begin
          t_m = 1'b1;
          for (int d = 0; d < 3; d++) if (dev_act[d] && !ids[d][pos_m]) t_m = 1'b0;
        end else if (ph_m == 1) begin
          c_m = 1'b1;
          for (int d = 0; d < 3; d++) if (dev_act[d] && ids[d][pos_m]) c_m = 1'b0;
        end else begin
          resolve(t_m, c_m, dir_cur[2*(pos_m % NB)+1], rr, ff);
          w_exp = rr;
        end
      end else begin
        slot_cyc++;
        if (drv) low_cnt++;
      end
      if (prev_drv && !drv && busy) begin
        exp_low = (ph_m == 2 && !w_exp) ? T_W0LOW : T_LOW;
        mchk(low_cnt == exp_low, "R3 low pulse width", low_cnt, exp_low);
      end
      if (ph_m == 0) dev_pull = !t_m && slot_cyc <= T_SAMPLE + 3;
      else if (ph_m == 1) dev_pull = !c_m && slot_cyc <= T_SAMPLE + 3;
      else dev_pull = 1'b0;
      if (ph_m == 2 && slot_cyc == T_SAMPLE) begin
        for (int d = 0; d < 3; d++) if (ids[d][pos_m] != !drv) dev_act[d] = 1'b0;
      end
      prev_drv  = drv;
      prev_busy = busy;
    end
  end

  // ---------------- stimulus side ----------------
  logic [2:0] ref_act;

  task automatic chk(input bit ok, input string msg, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", msg, act, exp, $time);
    end
  endtask

  // Expected response byte: R4/R5/R6 decisions packed as R7 describes.
  task automatic ref_step(input int xi, input logic [7:0] dir, output logic [7:0] resp);
    logic t, c, r, f;
    int   pos;
    for (int k = 0; k < NB; k++) begin
      pos = xi * NB + k;
      t = 1'b1; c = 1'b1;
      for (int d = 0; d < 3; d++)
        if (ref_act[d]) begin
          if (!ids[d][pos]) t = 1'b0; else c = 1'b0;
        end
      resolve(t, c, dir[2*k+1], r, f);
      resp[2*k+1] = r;
      resp[2*k]   = f;
      for (int d = 0; d < 3; d++) if (ids[d][pos] != r) ref_act[d] = 1'b0;
    end
  endtask

  task automatic xchg(input logic [7:0] dir, input int xi, input string tag, input bit poke);
    logic [7:0] exp;
    int base, waited;
    ref_step(xi, dir, exp);
    dir_cur = dir;
    base    = tot_slots;
    tx_data = dir;
    tx_wr   = 1'b1;
    @(posedge clk); #1;
    tx_wr = 1'b0;
    if (poke) begin
      // R9: a second write during the exchange must not disturb it
      repeat (50) @(posedge clk);
      #1; tx_data = ~dir; tx_wr = 1'b1;
      @(posedge clk); #1; tx_wr = 1'b0;
    end
    waited = 0;
    while (!rx_full && waited < 4000) begin
      @(posedge clk); #1; waited++;
    end
    chk(rx_full, "R8 response delivered", rx_full, 1);
    chk(tot_slots - base == 3 * NB, "R2 slots per exchange", tot_slots - base, 3 * NB);
    chk(slot_cyc == T_SLOT - 1, "R8 delivery right after last slot", slot_cyc, T_SLOT - 1);
    chk(rx_data == exp, tag, rx_data, exp);
    rx_rd = 1'b1;
    @(posedge clk); #1;
    rx_rd = 1'b0;
    chk(!rx_full, "R8 cleared by read", rx_full, 0);
  endtask

  // mode: 0 = all directions 0, 1 = all directions 1, 2 = random directions
  task automatic search(input logic [2:0] present, input int mode, input string tag,
                        input int poke_at);
    logic [7:0] dir;
    srch_base = tot_slots;
    dev_init  = present;
    ref_act   = present;
    srch_gen++;
    @(posedge clk); #1;
    for (int x = 0; x < 64 / NB; x++) begin
      dir = (mode == 0) ? 8'h00 : (mode == 1) ? 8'hFF : 8'($urandom);
      xchg(dir, x, tag, x == poke_at);
    end
  endtask

  initial begin
    int base;
    void'($urandom(32'd20240611));
    for (int d = 0; d < 3; d++) ids[d] = 64'd0;
    repeat (5) @(posedge clk);
    #1; rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    chk(!busy, "R1 busy after reset", busy, 0);
    chk(!rx_full, "R1 rx_full after reset", rx_full, 0);
    chk(!drv, "R1 bus released after reset", drv, 0);

    // R9: write with search mode off
    base = tot_slots;
    tx_data = 8'h5A; tx_wr = 1'b1;
    @(posedge clk); #1; tx_wr = 1'b0;
    repeat (40) @(posedge clk);
    #1;
    chk(tot_slots == base, "R9 no slots while disabled", tot_slots - base, 0);
    chk(!busy && !rx_full, "R9 no exchange while disabled", {busy, rx_full}, 0);

    srch_en = 1'b1;

    // R7: single device with a known low nibble 1010 -> 0x88
    ids[0] = {$urandom, $urandom};
    ids[0][3:0] = 4'b1010;
    ref_act = 3'b001;
    srch_base = tot_slots; dev_init = 3'b001; srch_gen++;
    @(posedge clk); #1;
    xchg(8'h00, 0, "R7 packing", 1'b0);
    chk(rx_data == 8'h88, "R7 packed nibble 1010", rx_data, 8'h88);
    for (int x = 1; x < 16; x++) xchg(8'($urandom), x, "R5 single device", 1'b0);

    // R4: two devices differing only in bit 0
    ids[0] = {$urandom, $urandom};
    ids[1] = ids[0] ^ 64'd1;
    search(3'b011, 0, "R4 conflict takes 0", -1);
    search(3'b011, 1, "R4 conflict takes 1", -1);

    // R6: nobody on the bus
    search(3'b000, 2, "R6 no responder", -1);
    chk(rx_data == 8'hFF, "R6 silent byte", rx_data, 8'hFF);

    // R5 and R4 mixed: random devices and directions, one busy poke (R9)
    for (int s = 0; s < 3; s++) begin
      for (int d = 0; d < 3; d++) ids[d] = {$urandom, $urandom};
      search(3'b111, 2, "R5 random search", (s == 0) ? 5 : -1);
    end

    // R10: abort in the middle of an exchange
    ids[0] = {$urandom, $urandom};
    srch_base = tot_slots; dev_init = 3'b001; srch_gen++;
    @(posedge clk); #1;
    base = tot_slots;
    tx_data = 8'h00; tx_wr = 1'b1;
    @(posedge clk); #1; tx_wr = 1'b0;
    repeat (30) @(posedge clk);
    #1; srch_en = 1'b0;
    @(posedge clk); #1;
    chk(!busy, "R10 busy drops on abort", busy, 0);
    chk(!drv, "R10 bus released on abort", drv, 0);
    repeat (300) @(posedge clk);
    #1;
    chk(!rx_full, "R10 no response after abort", rx_full, 0);
    chk(tot_slots - base == 2, "R10 no slots after abort", tot_slots - base, 2);
    srch_en = 1'b1;
    for (int d = 0; d < 3; d++) ids[d] = {$urandom, $urandom};
    search(3'b101, 2, "R10 recovery search", -1);

    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk + m_chk, n_fail + m_fail);
    $finish;
  end

endmodule